// File: doc/BRIEF.md
# Configurable I/O Cell Bank with Dual Feedback

This block is a bank of identical I/O cells that sit between a sum-of-products logic array and the device pins. Each cell owns one storage element that can be placed either on the path from the array to the pin or on the path from the pin back into the array. The storage element runs as an edge-triggered register or as a level-sensitive latch. Its clock comes from either a pin clock shared by the bank or a per-cell product-term clock, and the chosen clock can be inverted.

Every cell returns two lines to the array. One line carries the storage element's content and the other carries the live pin level. This lets a cell keep its register buried, feeding the array, while the pin acts as a plain input or as a combinational output. Nine configuration bits per cell select the behaviour.

The whole cell runs in the domain of the system clock `clk`. The pin clock and the product-term clock are sampled as ordinary signals. An "edge" of the effective clock is a change seen between two consecutive `clk` edges.

Top module: `mc_bank`

## Requirements
- R1: While `rst_n` is low, every `fb_store` bit is 0.
- R2: Configuration bit 0 picks the clock source. A value of 0 uses `pin_clk` and a value of 1 uses the cell's `pt_clk` bit.
- R3: Configuration bit 1 inverts the chosen clock to form the effective clock. With the bit set, register captures happen on falling source transitions.
- R4: In register mode (bit 2 = 0), the storage captures its data at a `clk` edge only when the effective clock is 1 at that edge and was 0 at the previous `clk` edge. It holds its value otherwise. The new value appears on `fb_store` right after that edge.
- R5: In latch mode (bit 2 = 1), the storage loads its data at every `clk` edge at which the effective clock is 1. It holds its value while the effective clock is 0.
- R6: With bit 3 set (input path), the storage data is the pin level `pin_in` and `pin_oe` is 0.
- R7: With bit 3 clear, the storage data is `sum_term`. Bit 4 = 1 drives the pin from the storage. Bit 4 = 0 drives the pin straight from `sum_term`, which leaves the register buried.
- R8: Bit 5 inverts the pin drive after the storage or bypass selection.
- R9: In output mode, bits 7:6 set `pin_oe`: 00 gives 0, 01 gives 1, 10 gives `oe_term`, and 11 gives the inverse of `oe_term`.
- R10: `fb_pin` always equals `pin_in`, and `fb_store` always equals the storage content, in every configuration.
- R11: With bit 8 set, the storage keeps its value regardless of clock and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | NUM_CELLS*CFG_W | Per-cell configuration, cell i at bits [i*CFG_W +: CFG_W] |
| pin_clk | input | 1 | Shared pin clock |
| pt_clk | input | NUM_CELLS | Per-cell product-term clock |
| sum_term | input | NUM_CELLS | Per-cell sum term from the array |
| oe_term | input | NUM_CELLS | Per-cell output-enable term |
| pin_in | input | NUM_CELLS | Sensed pin level |
| pin_out | output | NUM_CELLS | Pin drive value |
| pin_oe | output | NUM_CELLS | Pin drive enable |
| fb_store | output | NUM_CELLS | Feedback line carrying the storage content |
| fb_pin | output | NUM_CELLS | Feedback line carrying the pin level |

## Verification
`pin_out`, `pin_oe` and `fb_pin` are combinational, so they are due in the same cycle as the inputs that drive them. `fb_store` changes only at a `clk` edge and is due immediately after it. The bench drives new inputs at the falling edge and compares all four outputs 1 ns later against a model state. It then advances that model state just after the next rising edge, using the inputs that were present at the edge. This keeps every comparison one full register stage away from the edge that produces it.

// File: rtl/mc_pkg.sv
package mc_pkg;

   // per-cell configuration word, bit 0 is the LSB
   typedef struct packed {
      logic       hold;     // 8 freeze storage
      logic [1:0] oe_mode;  // 7:6 enable source
      logic       out_inv;  // 5 output polarity
      logic       out_reg;  // 4 pin driven from storage
      logic       in_path;  // 3 storage on input path
      logic       latch;    // 2 latch instead of register
      logic       clk_inv;  // 1 invert chosen clock
      logic       clk_sel;  // 0 product-term clock
   } mc_cfg_t;

   localparam int unsigned MC_CFG_BITS = $bits(mc_cfg_t);

   localparam logic [1:0] OE_OFF  = 2'b00;
   localparam logic [1:0] OE_ON   = 2'b01;
   localparam logic [1:0] OE_TERM = 2'b10;
   localparam logic [1:0] OE_NTRM = 2'b11;

endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
   parameter bit HAS_PT_CLK = 1'b1
) (
   input  logic pin_clk,
   input  logic pt_clk,
   input  logic clk_sel,
   input  logic clk_inv,
   output logic eff_clk
);

   logic src;

   generate
      if (HAS_PT_CLK) begin : g_sel
         assign src = clk_sel ? pt_clk : pin_clk;
      end else begin : g_pin
         logic unused_pt;
         assign unused_pt = pt_clk ^ clk_sel;
         assign src = pin_clk;
      end
   endgenerate

   assign eff_clk = src ^ clk_inv;

endmodule

// File: rtl/mc_store.sv
module mc_store #(
   parameter bit   HAS_LATCH = 1'b1,
   parameter logic RST_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eff_clk,
   input  logic latch,
   input  logic hold,
   input  logic d,
   output logic q
);

   logic ck_prev;
   logic rise;
   logic load;

   assign rise = eff_clk & ~ck_prev;

   generate
      if (HAS_LATCH) begin : g_lat
         assign load = ~hold & (latch ? eff_clk : rise);
      end else begin : g_reg
         logic unused_lat;
         assign unused_lat = latch;
         assign load = ~hold & rise;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_prev <= 1'b0;
         q       <= RST_VAL;
      end else begin
         ck_prev <= eff_clk;
         if (load) q <= d;
      end
   end

   // R11
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));

   // R4
   reg_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !latch && !(eff_clk && !ck_prev)) |=> $stable(q));

   // R4
   reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !latch && eff_clk && !ck_prev) |=> (q == $past(d)));

   // R5
   lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LATCH && !hold && latch && eff_clk) |=> (q == $past(d)));

endmodule

// File: rtl/mc_pad.sv
module mc_pad
   import mc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  mc_cfg_t cfg,
   input  logic    sum_term,
   input  logic    oe_term,
   input  logic    pin_in,
   input  logic    q,
   output logic    store_d,
   output logic    pin_out,
   output logic    pin_oe,
   output logic    fb_pin
);

   logic drive;

   assign store_d = cfg.in_path ? pin_in : sum_term;
   assign drive   = (cfg.out_reg && !cfg.in_path) ? q : sum_term;
   assign pin_out = drive ^ cfg.out_inv;
   assign fb_pin  = pin_in;

   always_comb begin
      if (cfg.in_path) pin_oe = 1'b0;
      else begin
         unique case (cfg.oe_mode)
            OE_OFF:  pin_oe = 1'b0;
            OE_ON:   pin_oe = 1'b1;
            OE_TERM: pin_oe = oe_term;
            default: pin_oe = ~oe_term;
         endcase
      end
   end

   // R6
   in_path_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.in_path |-> !pin_oe);

   // R10
   fb_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pin == pin_in);

   // R7
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.out_reg && !cfg.out_inv) |-> (pin_out == sum_term));

endmodule

// File: rtl/mc_bank.sv
module mc_bank
   import mc_pkg::*;
#(
   parameter int unsigned NUM_CELLS  = 4,
   parameter int unsigned CFG_W      = 9,
   parameter bit          HAS_LATCH  = 1'b1,
   parameter bit          HAS_PT_CLK = 1'b1,
   parameter logic        RST_VAL    = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CELLS*CFG_W-1:0]   cfg,
   input  logic                         pin_clk,
   input  logic [NUM_CELLS-1:0]         pt_clk,
   input  logic [NUM_CELLS-1:0]         sum_term,
   input  logic [NUM_CELLS-1:0]         oe_term,
   input  logic [NUM_CELLS-1:0]         pin_in,
   output logic [NUM_CELLS-1:0]         pin_out,
   output logic [NUM_CELLS-1:0]         pin_oe,
   output logic [NUM_CELLS-1:0]         fb_store,
   output logic [NUM_CELLS-1:0]         fb_pin
);

   localparam int unsigned CFG_TOTAL = NUM_CELLS * CFG_W;

   generate
      if (CFG_W != MC_CFG_BITS) begin : g_bad_w
         $error("mc_bank: CFG_W must equal the configuration word width");
      end
      if (NUM_CELLS < 1 || NUM_CELLS > 256) begin : g_bad_n
         $error("mc_bank: NUM_CELLS out of range");
      end
      if (CFG_TOTAL == 0) begin : g_bad_t
         $error("mc_bank: empty configuration");
      end
   endgenerate

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      mc_cfg_t c;
      logic    eff;
      logic    d;

      assign c = mc_cfg_t'(cfg[i*CFG_W +: CFG_W]);

      mc_clk_pick #(.HAS_PT_CLK(HAS_PT_CLK)) i_clk (
         .pin_clk (pin_clk),
         .pt_clk  (pt_clk[i]),
         .clk_sel (c.clk_sel),
         .clk_inv (c.clk_inv),
         .eff_clk (eff)
      );

      mc_store #(.HAS_LATCH(HAS_LATCH), .RST_VAL(RST_VAL)) i_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .eff_clk (eff),
         .latch   (c.latch),
         .hold    (c.hold),
         .d       (d),
         .q       (fb_store[i])
      );

      mc_pad i_pad (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (c),
         .sum_term (sum_term[i]),
         .oe_term  (oe_term[i]),
         .pin_in   (pin_in[i]),
         .q        (fb_store[i]),
         .store_d  (d),
         .pin_out  (pin_out[i]),
         .pin_oe   (pin_oe[i]),
         .fb_pin   (fb_pin[i])
      );
   end

   // R1
   reset_val_chk: assert property (@(posedge clk)
      !rst_n |=> (fb_store == {NUM_CELLS{RST_VAL}}) || !$past(!rst_n));

endmodule

// File: tb/test_mc_bank.sv
module test_mc_bank;
   localparam int N = 4;
   localparam int W = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N*W-1:0] cfg;
   logic           pin_clk;
   logic [N-1:0]   pt_clk, sum_term, oe_term, pin_in;
   logic [N-1:0]   pin_out, pin_oe, fb_store, fb_pin;

   mc_bank i_mc_bank (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .pin_clk(pin_clk), .pt_clk(pt_clk),
      .sum_term(sum_term), .oe_term(oe_term), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb_store(fb_store), .fb_pin(fb_pin)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [N-1:0] m_q, m_prev;

   function automatic logic [W-1:0] cf(int i);
      return cfg[i*W +: W];
   endfunction

   function automatic logic eff_of(int i);
      logic [W-1:0] c = cf(i);
      return (c[0] ? pt_clk[i] : pin_clk) ^ c[1];
   endfunction

   function automatic logic exp_oe(int i);
      logic [W-1:0] c = cf(i);
      if (c[3]) return 1'b0;
      case (c[7:6])
         2'b00:   return 1'b0;
         2'b01:   return 1'b1;
         2'b10:   return oe_term[i];
         default: return ~oe_term[i];
      endcase
   endfunction

   function automatic logic exp_out(int i);
      logic [W-1:0] c = cf(i);
      logic v = (c[4] && !c[3]) ? m_q[i] : sum_term[i];
      return v ^ c[5];
   endfunction

   task automatic chk(string lbl, string sig, int i, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s cell %0d actual %b expected %b", lbl, sig, i, act, exp);
      end
   endtask

   task automatic set_all(logic [W-1:0] c);
      for (int i = 0; i < N; i++) cfg[i*W +: W] = c;
   endtask

   task automatic step(string lbl);
      @(negedge clk);
      pin_clk  = 1'($urandom);
      pt_clk   = N'($urandom);
      sum_term = N'($urandom);
      oe_term  = N'($urandom);
      pin_in   = N'($urandom);
      #1;
      for (int i = 0; i < N; i++) begin
         chk(cf(i)[3] ? "R6 input path oe" : "R9 oe", "pin_oe", i, pin_oe[i], exp_oe(i));
         chk(cf(i)[5] ? "R8 polarity" : "R7 drive", "pin_out", i, pin_out[i], exp_out(i));
         chk("R10 pin feedback", "fb_pin", i, fb_pin[i], pin_in[i]);
         chk(lbl, "fb_store", i, fb_store[i], m_q[i]);
      end
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         logic [W-1:0] c = cf(i);
         logic e = eff_of(i);
         logic d = c[3] ? pin_in[i] : sum_term[i];
         if (!rst_n) begin
            m_q[i] = 1'b0; m_prev[i] = 1'b0;
         end else begin
            if (!c[8] && (c[2] ? e : (e && !m_prev[i]))) m_q[i] = d;
            m_prev[i] = e;
         end
      end
      #1;
   endtask

   task automatic run(string lbl, logic [W-1:0] c, int n);
      set_all(c);
      for (int k = 0; k < n; k++) step(lbl);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_q = '0; m_prev = '0;
      cfg = '0; pin_clk = 0; pt_clk = '0; sum_term = '0; oe_term = '0; pin_in = '0;
      // R1 reset with a capturing configuration applied
      set_all(9'b0_01_0_1_0_1_0_0);
      for (int k = 0; k < 6; k++) step("R1 reset");
      rst_n = 1'b1;
      //              hold oe  inv reg in lat cinv csel
      run("R2 R4 pin clock register",  9'b0_01_0_1_0_0_0_0, 150);
      run("R2 term clock register",    9'b0_10_0_1_0_0_0_1, 150);
      run("R3 inverted clock",         9'b0_11_1_1_0_0_1_0, 150);
      run("R3 inverted term clock",    9'b0_01_0_1_0_0_1_1, 150);
      run("R5 latch mode",             9'b0_01_0_1_0_1_0_0, 150);
      run("R5 inverted latch",         9'b0_10_1_1_0_1_1_1, 150);
      run("R6 input register",         9'b0_01_0_1_1_0_0_0, 150);
      run("R6 input latch",            9'b0_11_1_0_1_1_0_1, 150);
      run("R7 buried register",        9'b0_00_0_0_0_0_0_0, 150);
      run("R11 hold",                  9'b1_01_0_1_0_0_0_0, 100);
      run("R11 hold latch",            9'b1_01_0_1_1_1_0_1, 100);
      for (int r = 0; r < 150; r++) begin
         for (int i = 0; i < N; i++) cfg[i*W +: W] = W'($urandom);
         for (int k = 0; k < 12; k++) step("R4 R5 mixed configuration");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule